// File: doc/BRIEF.md
# Reset Cause Control Register

This block holds a single 32-bit status and control word that records why the system was last reset. It also lets software start a system reset by writing to that word. Only the five upper bits carry meaning; every other bit reads as zero.

Three of those bits record causes and are cleared by writing a one to them: power-on, button power-on and button externally-initiated reset. The two remaining bits are software triggers that store the written value. Writing a one to either trigger bit produces a single-cycle reset request pulse. Writing the soft power-on trigger also tells the block to treat the next reset as a power-on reset.

The block keeps a saturating count of the resets it has seen, so that it can tell the first reset from later ones. An asynchronous power-on input counts as the first reset and loads the power-on cause. A later system reset strobe reloads the power-on-only value only when the count has been zeroed by a soft power-on write. Button logic sets the two button cause bits through single-cycle strobes.

Top module: `rst_cause_reg`

## Requirements
- R1: While `porN` is low the word is 0x80000000 (only bit 31 set), `resetReq` is 0, and the reset count holds one, since power-on is the first reset.
- R2: The written data is masked to bits 31:27. Bits 26:0 always read 0, and writing ones to bits 26:0 alone changes nothing.
- R3: The word is live only at byte address `LIVE_BASE`+4, the word in the 8-byte block at `LIVE_BASE` that has address bit 2 set. The word at `LIVE_BASE` and every other address read 0 and ignore writes.
- R4: Bits 31 (power-on), 28 (button power-on) and 27 (button externally-initiated) are write-one-to-clear. Writing 0 to them leaves them unchanged.
- R5: Bits 30 (soft power-on) and 29 (soft externally-initiated) take the written value on every live write.
- R6: A live write with bit 30 set raises `resetReq` for exactly one cycle, on the clock edge after the write. It also zeroes the reset count.
- R7: A live write with bit 29 set and bit 30 clear raises the same one-cycle `resetReq` pulse and leaves the reset count unchanged.
- R8: On a `rstEvt` strobe with the reset count at zero, the word is loaded with only bit 31 set. With a nonzero count the word is unchanged. In both cases the count then increments.
- R9: The reset count saturates at its maximum (2^`CNT_W`-1) and never wraps back to zero.
- R10: `btnPor` sets bit 28 and `btnXir` sets bit 27. A strobe wins over a write-one-to-clear of the same bit in the same cycle.
- R11: A write in the same cycle as `rstEvt` is ignored: it changes no bit, requests no reset and does not touch the count.
- R12: The read data is combinational from `addr`: the current word at the live address, and 0 elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Asynchronous active-low power-on reset |
| rstEvt | input | 1 | One-cycle strobe: a system reset has occurred |
| btnPor | input | 1 | One-cycle strobe: button power-on cause |
| btnXir | input | 1 | One-cycle strobe: button externally-initiated cause |
| wrEn | input | 1 | Register write enable |
| addr | input | ADDR_W | Register byte address |
| wdata | input | 32 | Write data |
| rdData | output | 32 | Read data |
| resetReq | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with `CNT_W` = 2, so the reset count reaches its ceiling of three after two or three strobes. A handful of extra reset strobes then separates saturation from wrap-around: a counter that wraps would reload bit 31, and that reload is visible at the port. `ADDR_W` and `LIVE_BASE` keep their defaults, so the dead word at 0xF020 and the next block at 0xF028 are easy to reach.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int unsigned DATA_W = 32;

  localparam logic [DATA_W-1:0] KEEP_MASK  = 32'hF800_0000;
  localparam logic [DATA_W-1:0] W1C_MASK   = 32'h9800_0000;
  localparam logic [DATA_W-1:0] PLAIN_MASK = 32'h6000_0000;

  localparam int unsigned POR_POS     = 31;
  localparam int unsigned SOFT_POR_POS = 30;
  localparam int unsigned SOFT_XIR_POS = 29;
  localparam int unsigned BTN_POR_POS  = 28;
  localparam int unsigned BTN_XIR_POS  = 27;

  localparam logic [DATA_W-1:0] POR_ONLY = 32'h8000_0000;

  typedef struct packed {
    logic wrLive;   // accepted write to the live word
    logic loadPor;  // reload power-on-only value
    logic rdLive;   // address selects the live word
  } rcc_ctl_t;
endpackage

// File: rtl/rcc_ctrl.sv
module rcc_ctrl
  import rcc_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] LIVE_BASE = 16'hF020,
  parameter int unsigned CNT_W = 4
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              rstEvt,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output rcc_ctl_t          ctl,
  output logic              resetReq
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cntQ;
  logic             blockHit;
  logic             liveHit;
  logic             softPor;
  logic             softXir;

  assign blockHit = (addr[ADDR_W-1:3] == LIVE_BASE[ADDR_W-1:3]);
  assign liveHit  = blockHit & addr[2];

  always_comb begin
    ctl.rdLive  = liveHit;
    ctl.wrLive  = wrEn & liveHit & ~rstEvt;
    ctl.loadPor = rstEvt & (cntQ == '0);
  end

  assign softPor = ctl.wrLive & wdata[SOFT_POR_POS];
  assign softXir = ctl.wrLive & wdata[SOFT_XIR_POS] & ~wdata[SOFT_POR_POS];

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      cntQ <= CNT_ONE;
    end else if (rstEvt) begin
      if (cntQ != CNT_MAX) cntQ <= cntQ + CNT_ONE;
    end else if (softPor) begin
      cntQ <= '0;
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) resetReq <= 1'b0;
    else       resetReq <= softPor | softXir;
  end
endmodule

// File: rtl/rcc_datapath.sv
module rcc_datapath
  import rcc_pkg::*;
(
  input  logic              clk,
  input  logic              porN,
  input  rcc_ctl_t          ctl,
  input  logic [DATA_W-1:0] wdata,
  input  logic              btnPor,
  input  logic              btnXir,
  output logic [DATA_W-1:0] causeQ,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] maskedData;
  logic [DATA_W-1:0] causeNxt;

  assign maskedData = wdata & KEEP_MASK;

  always_comb begin
    causeNxt = causeQ;
    if (ctl.wrLive) begin
      causeNxt = (causeQ & ~(maskedData & W1C_MASK) & ~PLAIN_MASK)
               | (maskedData & PLAIN_MASK);
    end
    if (btnPor) causeNxt[BTN_POR_POS] = 1'b1;
    if (btnXir) causeNxt[BTN_XIR_POS] = 1'b1;
    if (ctl.loadPor) causeNxt = POR_ONLY;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) causeQ <= POR_ONLY;
    else       causeQ <= causeNxt & KEEP_MASK;
  end

  assign rdData = ctl.rdLive ? causeQ : '0;
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rcc_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] LIVE_BASE = 16'hF020,
  parameter int unsigned CNT_W = 4
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              rstEvt,
  input  logic              btnPor,
  input  logic              btnXir,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdData,
  output logic              resetReq
);
  rcc_ctl_t          ctl;
  logic [DATA_W-1:0] causeQ;

  rcc_ctrl #(
    .ADDR_W   (ADDR_W),
    .LIVE_BASE(LIVE_BASE),
    .CNT_W    (CNT_W)
  ) u_ctrl (
    .clk     (clk),
    .porN    (porN),
    .rstEvt  (rstEvt),
    .wrEn    (wrEn),
    .addr    (addr),
    .wdata   (wdata),
    .ctl     (ctl),
    .resetReq(resetReq)
  );

  rcc_datapath u_dp (
    .clk   (clk),
    .porN  (porN),
    .ctl   (ctl),
    .wdata (wdata),
    .btnPor(btnPor),
    .btnXir(btnXir),
    .causeQ(causeQ),
    .rdData(rdData)
  );
endmodule

// File: rtl/rst_cause_chk.sv
module rst_cause_chk
  import rcc_pkg::*;
(
  input logic        clk,
  input logic        porN,
  input logic        rstEvt,
  input logic        btnPor,
  input logic        btnXir,
  input logic        wrEn,
  input logic [31:0] wdata,
  input logic [31:0] rdData,
  input logic        resetReq,
  input rcc_ctl_t    ctl,
  input logic [31:0] causeQ
);
  // R6 R7
  req_source_chk: assert property (@(posedge clk) disable iff (!porN)
    resetReq |-> $past(ctl.wrLive && (wdata[30:29] != 2'b00)));

  // R2
  low_zero_chk: assert property (@(posedge clk) disable iff (!porN)
    rdData[26:0] == 27'd0);

  // R8
  por_load_chk: assert property (@(posedge clk) disable iff (!porN)
    ctl.loadPor |=> (causeQ == POR_ONLY));

  // R11
  collide_chk: assert property (@(posedge clk) disable iff (!porN)
    rstEvt |-> !ctl.wrLive);

  // R3
  dead_word_chk: assert property (@(posedge clk) disable iff (!porN)
    (wrEn && !ctl.rdLive && !rstEvt && !btnPor && !btnXir) |=> $stable(causeQ));

  // R5
  plain_take_chk: assert property (@(posedge clk) disable iff (!porN)
    (ctl.wrLive && !ctl.loadPor) |=> (causeQ[30:29] == $past(wdata[30:29])));

  // R4
  w1c_chk: assert property (@(posedge clk) disable iff (!porN)
    (ctl.wrLive && wdata[31] && !ctl.loadPor) |=> !causeQ[31]);
endmodule

bind rst_cause_reg rst_cause_chk u_chk (
  .clk     (clk),
  .porN    (porN),
  .rstEvt  (rstEvt),
  .btnPor  (btnPor),
  .btnXir  (btnXir),
  .wrEn    (wrEn),
  .wdata   (wdata),
  .rdData  (rdData),
  .resetReq(resetReq),
  .ctl     (ctl),
  .causeQ  (causeQ)
);

// File: tb/rst_cause_reg_tb.sv
module rst_cause_reg_tb;
  localparam logic [15:0] LIVE = 16'hF024;
  localparam logic [15:0] DEAD = 16'hF020;

  logic        clk = 1'b0;
  logic        porN = 1'b0;
  logic        rstEvt = 1'b0;
  logic        btnPor = 1'b0;
  logic        btnXir = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] addr = LIVE;
  logic [31:0] wdata = '0;
  logic [31:0] rdData;
  logic        resetReq;

  int nChk = 0;
  int nFail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rst_cause_reg #(.ADDR_W(16), .LIVE_BASE(16'hF020), .CNT_W(2)) u_dut (
    .clk(clk), .porN(porN), .rstEvt(rstEvt), .btnPor(btnPor), .btnXir(btnXir),
    .wrEn(wrEn), .addr(addr), .wdata(wdata), .rdData(rdData), .resetReq(resetReq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdData;
  endtask

  // drive on negedge; returns on the following negedge, after the capturing edge
  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; wdata = '0;
  endtask

  task automatic evt();
    @(negedge clk); rstEvt = 1'b1;
    @(negedge clk); rstEvt = 1'b0;
  endtask

  task automatic t_por();
    logic [31:0] v;
    rd(LIVE, v); chk("R1 word after power-on", v, 32'h8000_0000);
    chk("R1 no request after power-on", {31'd0, resetReq}, 32'd0);
    rd(DEAD, v); chk("R3 dead word reads zero", v, 32'd0);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wr(LIVE, 32'h8000_0000); rd(LIVE, v); chk("R4 clear bit31", v, 32'd0);
    @(negedge clk); btnPor = 1'b1; @(negedge clk); btnPor = 1'b0;
    rd(LIVE, v); chk("R10 button por sets bit28", v, 32'h1000_0000);
    @(negedge clk); btnXir = 1'b1; @(negedge clk); btnXir = 1'b0;
    rd(LIVE, v); chk("R10 button xir sets bit27", v, 32'h1800_0000);
    wr(LIVE, 32'h1000_0000); rd(LIVE, v); chk("R4 clear bit28 only", v, 32'h0800_0000);
    wr(LIVE, 32'h0000_0000); rd(LIVE, v); chk("R4 writing zero keeps bit27", v, 32'h0800_0000);
    wr(LIVE, 32'h0800_0000); rd(LIVE, v); chk("R4 clear bit27", v, 32'd0);
    @(negedge clk);
    btnPor = 1'b1; addr = LIVE; wdata = 32'h1000_0000; wrEn = 1'b1;
    @(negedge clk);
    btnPor = 1'b0; wrEn = 1'b0; wdata = '0;
    rd(LIVE, v); chk("R10 strobe beats clear", v, 32'h1000_0000);
    wr(LIVE, 32'h1000_0000); rd(LIVE, v); chk("R4 clear after collision", v, 32'd0);
  endtask

  task automatic t_plain();
    logic [31:0] v;
    wr(LIVE, 32'h2000_0000);
    chk("R7 xir write pulses", {31'd0, resetReq}, 32'd1);
    rd(LIVE, v); chk("R5 bit29 stored", v, 32'h2000_0000);
    @(negedge clk); chk("R7 pulse lasts one cycle", {31'd0, resetReq}, 32'd0);
    wr(LIVE, 32'h0000_0000);
    chk("R5 zero write no pulse", {31'd0, resetReq}, 32'd0);
    rd(LIVE, v); chk("R5 bit29 takes zero", v, 32'd0);
    wr(LIVE, 32'h07FF_FFFF);
    rd(LIVE, v); chk("R2 low bits masked", v, 32'd0);
    chk("R2 low bits no pulse", {31'd0, resetReq}, 32'd0);
  endtask

  task automatic t_dead();
    logic [31:0] v;
    wr(DEAD, 32'hFFFF_FFFF);
    chk("R3 dead write no pulse", {31'd0, resetReq}, 32'd0);
    rd(LIVE, v); chk("R3 dead write ignored", v, 32'd0);
    wr(16'hF02C, 32'hFFFF_FFFF);
    rd(LIVE, v); chk("R3 outside block ignored", v, 32'd0);
    rd(16'hF02C, v); chk("R12 outside block reads zero", v, 32'd0);
  endtask

  task automatic t_xir_count();
    logic [31:0] v;
    evt(); rd(LIVE, v); chk("R8 nonzero count holds word", v, 32'd0);
    wr(LIVE, 32'h2000_0000);
    chk("R7 second xir pulse", {31'd0, resetReq}, 32'd1);
    evt(); rd(LIVE, v); chk("R7 xir leaves count", v, 32'h2000_0000);
    wr(LIVE, 32'h0000_0000);
  endtask

  task automatic t_softpor();
    logic [31:0] v;
    wr(LIVE, 32'h4000_0000);
    chk("R6 soft por pulses", {31'd0, resetReq}, 32'd1);
    rd(LIVE, v); chk("R5 bit30 stored", v, 32'h4000_0000);
    @(negedge clk); chk("R6 pulse lasts one cycle", {31'd0, resetReq}, 32'd0);
    evt(); rd(LIVE, v); chk("R8 zero count reloads por", v, 32'h8000_0000);
    wr(LIVE, 32'h8000_0000);
    evt(); rd(LIVE, v); chk("R8 count increments after reload", v, 32'd0);
  endtask

  task automatic t_sat();
    logic [31:0] v;
    for (int i = 0; i < 4; i++) evt();
    rd(LIVE, v); chk("R9 count saturates", v, 32'd0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    @(negedge clk); btnPor = 1'b1; @(negedge clk); btnPor = 1'b0;
    @(negedge clk);
    rstEvt = 1'b1; addr = LIVE; wdata = 32'h5000_0000; wrEn = 1'b1;
    @(negedge clk);
    rstEvt = 1'b0; wrEn = 1'b0; wdata = '0;
    chk("R11 collided write no pulse", {31'd0, resetReq}, 32'd0);
    rd(LIVE, v); chk("R11 collided write ignored", v, 32'h1000_0000);
    evt(); rd(LIVE, v); chk("R11 count not zeroed", v, 32'h1000_0000);
  endtask

  initial begin
    #100000000;
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    porN = 1'b1;
    @(negedge clk);
    t_por();
    t_w1c();
    t_plain();
    t_dead();
    t_xir_count();
    t_softpor();
    t_sat();
    t_collide();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule